// File: doc/BRIEF.md
# External Memory Block Transfer Sequencer

This block moves a run of bytes between the local side and an external byte-wide memory with a 19-bit address. It handles three jobs: it can fill a range with one constant byte, copy bytes that arrive on a local source stream into a range, or read a range back out onto a local sink stream. The memory side uses three active-low strobes. A memory-request strobe frames the whole run, and a write or read strobe is pulsed once per byte while the address steps upward by one.

A transfer starts with a one-cycle start pulse that carries the operation code, base address, byte count and fill byte. The block raises busy until it finishes, then pulses done once. It assumes that the external bus is already owned, so it does not arbitrate. The data bus enable goes high only for fill and write jobs.

Top module: `xmem_seq`

## Requirements
- R1: mreq_n is low from the cycle before the first byte's strobe until after the last byte's strobe has risen, and it stays low between bytes. rd_n or wr_n is never low while mreq_n is high.
- R2: For each byte, mem_addr is set at least one cycle before the strobe falls, and it stays unchanged for as long as the strobe is low.
- R3: A write or fill strobe holds wr_n low for exactly WR_LOW cycles (default 2). mem_doe is high and mem_dout is stable from the cycle before wr_n falls until wr_n rises.
- R4: A read strobe holds rd_n low for exactly RD_LOW cycles (default 3). mem_din is captured on the clock edge that ends the last low cycle. mem_doe is low during a read.
- R5: The address starts at base_addr and rises by one per byte. It wraps from 19'h7FFFF to 19'h00000.
- R6: op encoding is 2'b00 fill, 2'b01 write, 2'b10 read. A fill writes fill_byte at every address of the range and never raises src_ready.
- R7: A write takes one byte per address from the source stream in arrival order, with a transfer when src_valid and src_ready are both high. While src_valid is low, the block waits with mreq_n low and issues no strobe.
- R8: A read presents each byte on snk_data with snk_valid high, in address order. It holds the byte stable and issues no further strobe until snk_ready is high.
- R9: A length of zero, or op 2'b11, completes with done and produces no rd_n, wr_n or mreq_n pulse.
- R10: done is a single-cycle pulse with mreq_n high, and busy is high from the cycle after start until done. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (sampled when idle) |
| op | input | 2 | Operation code |
| base_addr | input | 19 | First address |
| length | input | 32 | Byte count |
| fill_byte | input | 8 | Constant for fill |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| src_data | input | 8 | Write-stream byte |
| src_valid | input | 1 | Write-stream byte available |
| src_ready | output | 1 | Block accepts a write-stream byte |
| snk_data | output | 8 | Read-stream byte |
| snk_valid | output | 1 | Read-stream byte available |
| snk_ready | input | 1 | Sink accepts the byte |
| mem_addr | output | 19 | Memory address |
| mem_dout | output | 8 | Data driven toward memory |
| mem_din | input | 8 | Data returned from memory |
| mem_doe | output | 1 | Data bus output enable |
| mreq_n | output | 1 | Memory request, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bench uses the default parameters: a 19-bit address, a 32-bit length, WR_LOW of 2 and RD_LOW of 3. With the 19-bit address, the wrap from 19'h7FFFF to zero can be reached in a three-byte fill. With the 2- and 3-cycle strobe widths, every width can be counted one cycle at a time. The memory model in the bench returns correct read data only during the last low cycle of rd_n, so a capture made one cycle early is detected. The source and sink stalls are timed so that a strobe issued during a stall is counted.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  typedef enum logic [1:0] {
    OP_FILL  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_NONE  = 2'b11
  } xop_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_OPEN,
    S_FETCH,
    S_SETUP,
    S_STROBE,
    S_RECOVER,
    S_PUSH,
    S_CLOSE
  } xst_e;

  // true when the operation drives the data bus toward memory
  function automatic logic op_drives(input xop_e o);
    return (o == OP_FILL) || (o == OP_WRITE);
  endfunction

  // true when the state keeps the request strobe asserted
  function automatic logic st_framed(input xst_e s);
    return (s != S_IDLE) && (s != S_CLOSE);
  endfunction

endpackage

// File: rtl/xmem_walker.sv
module xmem_walker #(
  parameter int AW = 19,
  parameter int LW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic          last
);

  localparam logic [AW-1:0] ONE_A = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [LW-1:0] ONE_L = {{(LW-1){1'b0}}, 1'b1};

  function automatic logic [AW-1:0] addr_after(input logic [AW-1:0] a);
    return a + ONE_A;
  endfunction

  logic [LW-1:0] remaining;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr      <= '0;
      remaining <= '0;
    end else if (load) begin
      addr      <= base;
      remaining <= len;
    end else if (step) begin
      addr      <= addr_after(addr);
      remaining <= remaining - ONE_L;
    end
  end

  assign last = (remaining == ONE_L);

endmodule

// File: rtl/xmem_pulse.sv
module xmem_pulse #(
  parameter int WR_LOW = 2,
  parameter int RD_LOW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic is_read,
  output logic expire
);

  localparam int MAXW = (WR_LOW > RD_LOW) ? WR_LOW : RD_LOW;
  localparam int CW   = $clog2(MAXW + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim    = is_read ? CW'(RD_LOW - 1) : CW'(WR_LOW - 1);
  assign expire = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (!expire) cnt <= cnt + 1'b1;
  end

  // R3 / R4: the width counter never passes its limit
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= lim));

endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int AW     = 19,
  parameter int DW     = 8,
  parameter int LW     = 32,
  parameter int WR_LOW = 2,
  parameter int RD_LOW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [AW-1:0] base_addr,
  input  logic [LW-1:0] length,
  input  logic [DW-1:0] fill_byte,
  output logic          busy,
  output logic          done,
  input  logic [DW-1:0] src_data,
  input  logic          src_valid,
  output logic          src_ready,
  output logic [DW-1:0] snk_data,
  output logic          snk_valid,
  input  logic          snk_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  input  logic [DW-1:0] mem_din,
  output logic          mem_doe,
  output logic          mreq_n,
  output logic          rd_n,
  output logic          wr_n
);

  xst_e          state, state_nx;
  xop_e          op_q;
  logic [DW-1:0] wbuf, rbuf;
  logic          load, step, last, expire;
  logic          in_strobe, no_work;

  // named internal events
  assign in_strobe = (state == S_STROBE);
  assign no_work   = (length == '0) || (xop_e'(op) == OP_NONE);
  assign load      = (state == S_IDLE) && start;
  assign step      = ((state == S_RECOVER) && (op_q != OP_READ)) ||
                     ((state == S_PUSH) && snk_ready);

  xmem_walker #(.AW(AW), .LW(LW)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(load), .base(base_addr),
    .len(length), .step(step), .addr(mem_addr), .last(last)
  );

  xmem_pulse #(.WR_LOW(WR_LOW), .RD_LOW(RD_LOW)) u_pulse (
    .clk(clk), .rst_n(rst_n), .run(in_strobe),
    .is_read(op_q == OP_READ), .expire(expire)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:    if (start) state_nx = no_work ? S_CLOSE : S_OPEN;
      S_OPEN:    state_nx = (op_q == OP_WRITE) ? S_FETCH : S_SETUP;
      S_FETCH:   if (src_valid) state_nx = S_SETUP;
      S_SETUP:   state_nx = S_STROBE;
      S_STROBE:  if (expire) state_nx = S_RECOVER;
      S_RECOVER: begin
        if (op_q == OP_READ)       state_nx = S_PUSH;
        else if (last)             state_nx = S_CLOSE;
        else if (op_q == OP_WRITE) state_nx = S_FETCH;
        else                       state_nx = S_SETUP;
      end
      S_PUSH:    if (snk_ready) state_nx = last ? S_CLOSE : S_SETUP;
      S_CLOSE:   state_nx = S_IDLE;
      default:   state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      op_q  <= OP_NONE;
      wbuf  <= '0;
      rbuf  <= '0;
    end else begin
      state <= state_nx;
      if (load) begin
        op_q <= xop_e'(op);
        wbuf <= fill_byte;
      end
      if ((state == S_FETCH) && src_valid) wbuf <= src_data;
      if (expire && (op_q == OP_READ))     rbuf <= mem_din;
    end
  end

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_CLOSE);
  assign src_ready = (state == S_FETCH);
  assign snk_valid = (state == S_PUSH);
  assign snk_data  = rbuf;
  assign mem_dout  = wbuf;
  assign mreq_n    = !st_framed(state);
  assign mem_doe   = st_framed(state) && op_drives(op_q);
  assign wr_n      = !(in_strobe && (op_q != OP_READ));
  assign rd_n      = !(in_strobe && (op_q == OP_READ));

  // assertion-side counters of strobe low time
  logic [7:0] wr_low_run, rd_low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_low_run <= '0;
      rd_low_run <= '0;
    end else begin
      wr_low_run <= wr_n ? 8'd0 : wr_low_run + 8'd1;
      rd_low_run <= rd_n ? 8'd0 : rd_low_run + 8'd1;
    end
  end

  a_r1_strobe_framed: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || !rd_n) |-> !mreq_n);
  a_r1_close_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mreq_n) |-> done);
  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || !rd_n) |-> $stable(mem_addr));
  a_r3_wr_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (wr_low_run == 8'(WR_LOW)));
  a_r3_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ($stable(mem_dout) && mem_doe));
  a_r4_rd_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> (rd_low_run == 8'(RD_LOW)));
  a_r4_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !mem_doe);
  a_r7_fetch_only_write: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> ((op_q == OP_WRITE) && !mreq_n && wr_n));
  a_r8_sink_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (snk_valid && !snk_ready) |=> (snk_valid && $stable(snk_data)));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/sim_xmem_seq.sv
module sim_xmem_seq;

  localparam int AW = 19;
  localparam int WRL = 2;
  localparam int RDL = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    op = 2'b00;
  logic [AW-1:0] base_addr = '0;
  logic [31:0]   length = '0;
  logic [7:0]    fill_byte = '0;
  logic          busy, done;
  logic [7:0]    src_data = '0;
  logic          src_valid = 1'b0;
  logic          src_ready;
  logic [7:0]    snk_data;
  logic          snk_valid;
  logic          snk_ready = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_dout;
  logic [7:0]    mem_din = '0;
  logic          mem_doe, mreq_n, rd_n, wr_n;

  always #2.5 clk = ~clk;

  xmem_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .base_addr(base_addr),
    .length(length), .fill_byte(fill_byte), .busy(busy), .done(done),
    .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
    .snk_data(snk_data), .snk_valid(snk_valid), .snk_ready(snk_ready),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_din(mem_din),
    .mem_doe(mem_doe), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  int tests = 0, fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ {a[15:11], a[18:16]} ^ 8'hA5;
  endfunction

  // memory-side monitor and read responder
  int            wcnt = 0, rcnt = 0, wr_run = 0, rd_run = 0;
  bit            mreq_seen = 0;
  logic [AW-1:0] wlog_a [64];
  logic [7:0]    wlog_d [64];
  logic [AW-1:0] rlog_a [64];

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mreq_n) mreq_seen = 1;
      if ((!wr_n || !rd_n) && mreq_n) check(0, "R1", "strobe outside mreq", 1, 0);
      if (!wr_n) begin
        if (wr_run == 0) begin
          wlog_a[wcnt & 63] = mem_addr;
          wlog_d[wcnt & 63] = mem_dout;
        end else if (mem_addr != wlog_a[wcnt & 63])
          check(0, "R2", "addr moved during wr", mem_addr, wlog_a[wcnt & 63]);
        else if (mem_dout != wlog_d[wcnt & 63])
          check(0, "R3", "data moved during wr", mem_dout, wlog_d[wcnt & 63]);
        if (!mem_doe) check(0, "R3", "doe low during wr", 0, 1);
        wr_run++;
      end else if (wr_run > 0) begin
        check(wr_run == WRL, "R3", "wr low width", wr_run, WRL);
        wcnt++;
        wr_run = 0;
      end
      if (!rd_n) begin
        if (rd_run == 0) rlog_a[rcnt & 63] = mem_addr;
        else if (mem_addr != rlog_a[rcnt & 63])
          check(0, "R2", "addr moved during rd", mem_addr, rlog_a[rcnt & 63]);
        if (mem_doe) check(0, "R4", "doe high during rd", 1, 0);
        rd_run++;
      end else if (rd_run > 0) begin
        check(rd_run == RDL, "R4", "rd low width", rd_run, RDL);
        rcnt++;
        rd_run = 0;
      end
      // correct data only in the last low cycle of the read strobe
      mem_din = (!rd_n && rd_run == RDL) ? pat(mem_addr) : ~pat(mem_addr);
    end
  end

  // source stream model
  logic [7:0] src_mem [64];
  int src_n = 0, src_idx = 0, src_stall_at = -1, src_stall_len = 0, stall_ctr = 0;
  bit src_fire = 0, stall_done = 0, snap_mreq = 1;
  int snap_wr = -1;

  always @(negedge clk) begin
    if (src_fire) src_idx++;
    if (src_idx == src_stall_at && !stall_done) begin
      stall_ctr  = src_stall_len;
      stall_done = 1;
    end
    if (stall_ctr > 0) begin
      stall_ctr--;
      if (stall_ctr == 0) begin
        snap_wr   = wcnt;
        snap_mreq = mreq_n;
      end
      src_valid = 1'b0;
    end else src_valid = (src_idx < src_n);
    src_data = src_mem[src_idx & 63];
    src_fire = src_valid && src_ready;
  end

  // sink stream model
  logic [7:0] snk_log [64];
  int snk_cnt = 0, snk_hold = 0, snap_rd = -1;
  bit snk_stable = 1;
  logic [7:0] snk_first;

  always @(negedge clk) begin
    if (snk_valid && snk_hold > 0) begin
      if (snk_cnt == 0 && snk_hold == 8) snk_first = snk_data;
      else if (snk_data != snk_first) snk_stable = 0;
      snk_hold--;
      if (snk_hold == 0) snap_rd = rcnt;
      snk_ready = 1'b0;
    end else snk_ready = 1'b1;
    if (snk_valid && snk_ready) begin
      snk_log[snk_cnt & 63] = snk_data;
      snk_cnt++;
    end
  end

  task automatic clear_logs();
    wcnt = 0; rcnt = 0; snk_cnt = 0; mreq_seen = 0;
  endtask

  // launch one transfer and wait for done; returns cycles taken
  task automatic run_op(input logic [1:0] o, input logic [AW-1:0] b,
                        input logic [31:0] n, input logic [7:0] f, output int cyc);
    @(negedge clk);
    clear_logs();
    op = o; base_addr = b; length = n; fill_byte = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    check(busy || done, "R10", "busy after start", busy, 1);
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    check(done, "R10", "done seen", done, 1);
    check(mreq_n, "R10", "mreq_n high with done", mreq_n, 1);
    @(negedge clk);
    check(!done && !busy, "R10", "done one cycle then idle", done, 0);
  endtask

  task automatic t_reset();
    check(mreq_n && rd_n && wr_n, "R1", "strobes idle in reset", {mreq_n, rd_n, wr_n}, 3'b111);
    check(!mem_doe, "R4", "bus released in reset", mem_doe, 0);
    check(!busy && !done, "R10", "idle in reset", {busy, done}, 0);
    check(!src_ready && !snk_valid, "R7", "streams idle in reset", {src_ready, snk_valid}, 0);
  endtask

  task automatic t_fill();
    int c;
    run_op(2'b00, 19'h01230, 32'd5, 8'h3C, c);
    check(wcnt == 5, "R6", "fill strobe count", wcnt, 5);
    check(rcnt == 0, "R6", "fill no reads", rcnt, 0);
    for (int i = 0; i < 5; i++) begin
      check(wlog_a[i] == 19'h01230 + i, "R5", "fill address", wlog_a[i], 19'h01230 + i);
      check(wlog_d[i] == 8'h3C, "R6", "fill data", wlog_d[i], 8'h3C);
    end
  endtask

  task automatic t_write();
    int c;
    for (int i = 0; i < 6; i++) src_mem[i] = 8'h90 + 8'(i * 7);
    src_idx = 0; src_n = 6; src_stall_at = 1; src_stall_len = 12; stall_done = 0;
    run_op(2'b01, 19'h40000, 32'd6, 8'hFF, c);
    check(wcnt == 6, "R7", "write strobe count", wcnt, 6);
    check(src_idx == 6, "R7", "source bytes consumed", src_idx, 6);
    check(snap_wr == 1, "R7", "no strobe while source stalled", snap_wr, 1);
    check(snap_mreq == 0, "R1", "mreq held during stall", snap_mreq, 0);
    for (int i = 0; i < 6; i++) begin
      check(wlog_a[i] == 19'h40000 + i, "R5", "write address", wlog_a[i], 19'h40000 + i);
      check(wlog_d[i] == src_mem[i], "R7", "write data order", wlog_d[i], src_mem[i]);
    end
    src_n = 0; src_idx = 0; src_stall_at = -1;
  endtask

  task automatic t_read();
    int c;
    snk_hold = 8; snk_stable = 1; snap_rd = -1;
    run_op(2'b10, 19'h2ABC0, 32'd4, 8'h00, c);
    check(rcnt == 4, "R8", "read strobe count", rcnt, 4);
    check(wcnt == 0, "R4", "read no writes", wcnt, 0);
    check(snk_cnt == 4, "R8", "sink bytes", snk_cnt, 4);
    check(snap_rd == 1, "R8", "no strobe while sink stalled", snap_rd, 1);
    check(snk_stable, "R8", "sink data held", snk_stable, 1);
    for (int i = 0; i < 4; i++)
      check(snk_log[i] == pat(19'h2ABC0 + i), "R4", "read data sampled late",
            snk_log[i], pat(19'h2ABC0 + i));
  endtask

  task automatic t_empty();
    int c;
    run_op(2'b00, 19'h00010, 32'd0, 8'h11, c);
    check(wcnt == 0 && rcnt == 0, "R9", "zero length no strobes", wcnt + rcnt, 0);
    check(!mreq_seen, "R9", "zero length no mreq", mreq_seen, 0);
    check(c == 1, "R9", "zero length done latency", c, 1);
    run_op(2'b11, 19'h00010, 32'd4, 8'h11, c);
    check(wcnt == 0 && rcnt == 0 && !mreq_seen, "R9", "reserved op idle", wcnt + rcnt + mreq_seen, 0);
  endtask

  task automatic t_wrap();
    int c;
    run_op(2'b00, 19'h7FFFE, 32'd3, 8'hA1, c);
    check(wlog_a[0] == 19'h7FFFE, "R5", "wrap addr0", wlog_a[0], 19'h7FFFE);
    check(wlog_a[1] == 19'h7FFFF, "R5", "wrap addr1", wlog_a[1], 19'h7FFFF);
    check(wlog_a[2] == 19'h00000, "R5", "wrap addr2", wlog_a[2], 0);
  endtask

  task automatic t_busy_start();
    int c;
    @(negedge clk);
    clear_logs();
    op = 2'b00; base_addr = 19'h00100; length = 32'd2; fill_byte = 8'h5A; start = 1'b1;
    @(negedge clk);
    op = 2'b10; length = 32'd5;   // second start while busy: must be ignored
    @(negedge clk);
    start = 1'b0;
    c = 0;
    while (!done && c < 2000) begin @(negedge clk); c++; end
    @(negedge clk);
    for (int k = 0; k < 20; k++) @(negedge clk);
    check(wcnt == 2, "R10", "first job completes alone", wcnt, 2);
    check(rcnt == 0, "R10", "ignored start no reads", rcnt, 0);
    check(!busy, "R10", "idle after ignored start", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_fill();
    t_write();
    t_read();
    t_empty();
    t_wrap();
    t_busy_start();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule